// File: doc/BRIEF.md
# Multi-Mode Addressable Latch Array

This block is a bank of single-bit storage cells that is written one bit at a time. A single serial data bit `din` goes to the cell picked by the binary address `addr`, and every cell drives its own parallel output bit in `q`. Two active-low controls select what happens on each rising clock edge. The controls are `le_n` (enable) and `mr_n` (clear). The four actions are:

- **Write:** a single-bit write to the addressed cell.
- **Hold:** every cell keeps its value.
- **Demultiplex:** the data bit is steered onto the addressed output and every other output is zero. With `din` high this works as a binary-to-one-hot decoder.
- **Clear:** every cell is zeroed.

All cells are registers, so each action takes effect at the clock edge where the controls are sampled. The outputs always show the registered cell contents. The width is set by the address width `ADDR_W`, with 2**ADDR_W cells. Wider arrays are built by placing several instances side by side and decoding the upper address bits outside them.

Typical uses:

- Serial-to-parallel conversion: write the bits one at a time, then hold.
- Decoding: enter demultiplex mode and keep it.

Callers should change `addr` only while in hold mode. The design samples the address on the clock, so a glitch cannot reach it, but that ordering is still the safe way to drive the block.

Top module: `addr_latch_array`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q` is all zeros after that edge, whatever the mode controls are.
- R2: In write mode (`le_n`=0, `mr_n`=1), after the edge the cell whose index equals `addr` (bit 0 of `addr` is the least significant) holds the `din` sampled at that edge.
- R3: In write mode, every cell other than the addressed one keeps its previous value.
- R4: In hold mode (`le_n`=1, `mr_n`=1), all cells keep their values, whatever `din` and `addr` are.
- R5: In demultiplex mode (`le_n`=0, `mr_n`=0), after the edge the output `q[addr]` equals `din` and every other output bit is 0.
- R6: In demultiplex mode with `din`=1, `q` is exactly one-hot, with the single 1 at index `addr`.
- R7: In clear mode (`le_n`=1, `mr_n`=0), `q` is all zeros after the edge, whatever `addr` and `din` are.
- R8: Moving from demultiplex or clear mode into hold mode keeps the one-hot or all-zero value present at the change. No value written before that mode can return.
- R9: After any sequence of writes and holds, `q` matches a bit array in which each write replaced only the addressed entry with the data sampled in its last write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all actions take effect on its rising edge |
| rst_n | input | 1 | Synchronous active-low power-on initialisation to zero |
| le_n | input | 1 | Active-low enable; low selects write or demultiplex |
| mr_n | input | 1 | Active-low clear; low selects clear or demultiplex |
| din | input | 1 | Serial data bit |
| addr | input | ADDR_W | Binary index of the target cell |
| q | output | 2**ADDR_W | Registered cell contents, active high |

## Verification
The hardest case to reach from the ports is proving that a stored value cannot come back after demultiplex or clear mode. The ports show the same value for a cell that is really zeroed and for one whose old contents are only hidden. So the bench first fills every cell with ones and then enters demultiplex or clear mode. It then spends several cycles in hold mode with different addresses and data, and checks that only the one-hot or all-zero pattern remains. A random run of writes and holds, checked against a bench-side bit array, covers orderings that the directed loops over every address and both data values do not.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } alatch_mode_e;

endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
(
  input  logic         le_n,
  input  logic         mr_n,
  output alatch_mode_e mode
);

  always_comb begin
    unique case ({le_n, mr_n})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end

endmodule

// File: rtl/alatch_addr_dec.sv
module alatch_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  sel
);

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/alatch_bit_cell.sv
module alatch_bit_cell
  import alatch_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  alatch_mode_e mode,
  input  logic         sel,
  input  logic         din,
  output logic         q
);

  logic q_nxt;

  always_comb begin
    unique case (mode)
      MODE_WRITE: q_nxt = sel ? din : q;
      MODE_DEMUX: q_nxt = sel & din;
      MODE_CLEAR: q_nxt = 1'b0;
      default:    q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/addr_latch_array.sv
module addr_latch_array
  import alatch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_n,
  input  logic              mr_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  q
);

  alatch_mode_e     mode;
  logic [NBITS-1:0] sel;

  alatch_mode_dec u_mode (
    .le_n (le_n),
    .mr_n (mr_n),
    .mode (mode)
  );

  alatch_addr_dec #(.ADDR_W(ADDR_W)) u_adec (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    alatch_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .sel   (sel[i]),
      .din   (din),
      .q     (q[i])
    );
  end

endmodule

// File: rtl/addr_latch_array_chk.sv
module addr_latch_array_chk #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              le_n,
  input logic              mr_n,
  input logic              din,
  input logic [ADDR_W-1:0] addr,
  input logic [NBITS-1:0]  q
);

  // R1
  init_zero_chk: assert property (@(posedge clk) !rst_n |=> q == '0);

  // R2
  write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && mr_n) |=> q[$past(addr)] == $past(din));

  // R3
  for (genvar i = 0; i < NBITS; i++) begin : g_keep
    write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_n && mr_n && addr != ADDR_W'(i)) |=> q[i] == $past(q[i]));
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n && mr_n) |=> $stable(q));

  // R5
  demux_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && !mr_n) |=> q == ({{(NBITS-1){1'b0}}, $past(din)} << $past(addr)));

  // R6
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && !mr_n && din) |=> $countones(q) == 1);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n && !mr_n) |=> q == '0);

  // R8
  exit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mr_n) |=> $onehot0(q));

endmodule

bind addr_latch_array addr_latch_array_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .le_n  (le_n),
  .mr_n  (mr_n),
  .din   (din),
  .addr  (addr),
  .q     (q)
);

// File: tb/addr_latch_array_tb.sv
module addr_latch_array_tb;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          le_n = 1'b1;
  logic          mr_n = 1'b1;
  logic          din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  q;
  logic [N-1:0]  exp_q = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_latch_array #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .le_n(le_n), .mr_n(mr_n),
    .din(din), .addr(addr), .q(q)
  );

  task automatic check(input string req);
    n_chk++;
    if (q !== exp_q) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", req, q, exp_q);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at next falling edge.
  task automatic step(input logic le, input logic mr, input logic d,
                      input logic [AW-1:0] a, input string req);
    le_n = le; mr_n = mr; din = d; addr = a;
    if (!rst_n)            exp_q = '0;
    else if (!le && mr)    exp_q[a] = d;
    else if (!le && !mr)   begin exp_q = '0; exp_q[a] = d; end
    else if (le && !mr)    exp_q = '0;
    @(negedge clk);
    check(req);
  endtask

  task automatic fill(input logic [N-1:0] pat);
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, pat[i], AW'(i), "R2");
  endtask

  task automatic t_reset;
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, AW'(2), "R1");
    rst_n = 1'b1;
    fill('1);
    rst_n = 1'b0;
    step(1'b0, 1'b1, 1'b1, AW'(5), "R1");
    rst_n = 1'b1;
  endtask

  task automatic t_write;
    fill(N'('h5a));
    for (int a = 0; a < N; a++)
      for (int d = 0; d < 2; d++)
        step(1'b0, 1'b1, d[0], AW'(a), "R2 R3");
    fill(N'('h96));
  endtask

  task automatic t_hold;
    fill(N'('hc3));
    for (int a = 0; a < N; a++)
      for (int d = 0; d < 2; d++)
        step(1'b1, 1'b1, d[0], AW'(a), "R4");
  endtask

  task automatic t_demux;
    fill('1);
    for (int a = 0; a < N; a++) begin
      step(1'b0, 1'b0, 1'b0, AW'(a), "R5");
      step(1'b0, 1'b0, 1'b1, AW'(a), "R5 R6");
    end
  endtask

  task automatic t_clear;
    for (int a = 0; a < N; a++)
      for (int d = 0; d < 2; d++) begin
        fill('1);
        step(1'b1, 1'b0, d[0], AW'(a), "R7");
      end
  endtask

  task automatic t_exit;
    fill('1);
    step(1'b0, 1'b0, 1'b1, AW'(5), "R6");
    for (int a = 0; a < N; a++) step(1'b1, 1'b1, a[0], AW'(a), "R8");
    fill('1);
    step(1'b1, 1'b0, 1'b1, AW'(3), "R7");
    for (int a = 0; a < N; a++) step(1'b1, 1'b1, ~a[0], AW'(a), "R8");
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic wr;
      wr = ($urandom_range(0, 2) != 0);
      step(~wr, 1'b1, 1'($urandom), AW'($urandom), "R9");
    end
  endtask

  initial begin
    t_reset();
    t_write();
    t_hold();
    t_demux();
    t_clear();
    t_exit();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: q=%b expected completion", q);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule